// File: doc/BRIEF.md
# Tiled heat-diffusion stencil kernel

This block advances a two-dimensional explicit heat-diffusion update by one time step for a 3x3 tile of grid points on each accepted beat. A beat carries the 21 samples that the tile's five-point neighbourhoods touch: a 5x5 window of signed fixed-point values without its four corners. Nine updated values come out together a fixed number of cycles later. The kernel has no feedback path and no storage apart from its pipeline registers, so a new beat may enter on every clock.

Each output is a weighted sum. The horizontal pair is added first, then the vertical pair is added, and the centre stays on its own. The horizontal sum is scaled by one coefficient, the vertical sum by a second and the centre by a third. These three weights are held in registers inside the block. They load through a write strobe, and the block accepts a write only while no data is in flight. Outputs keep full precision, so no result can wrap. The caller reads the result with the same binary-point position that the product of sample and coefficient formats gives.

Top module: `heat_tile_pipe`

## Requirements
- R1: For tile point (p,q), with p as the row and q as the column, both 0..2, the window position is (r,c) = (p+1,q+1). The result is kx*(s[r][c-1]+s[r][c+1]) + ky*(s[r-1][c]+s[r+1][c]) + kc*s[r][c], computed exactly in signed arithmetic.
- R2: Input samples are packed row-major over the 5x5 window with the corners skipped. Window row 0 columns 1..3 are indices 0..2. Rows 1..3 columns 0..4 are indices 3..17. Row 4 columns 1..3 are indices 18..20. Sample k is `in_data[k*DW +: DW]`. Point (p,q) sits in `out_data[(3*p+q)*OW +: OW]`.
- R3: `out_valid` rises exactly four rising clock edges after the edge that captured `in_valid`. It is never high without such a beat.
- R4: Beats presented on consecutive clocks all come out, one per clock and in order, with no stall.
- R5: Each output is OW = DW+CW+3 bits, signed. It is exact for every combination of sample and coefficient values, including all at their most negative.
- R6: When `coef_we` is high and the pipeline is idle, the three coefficients load at that edge and apply to every beat that enters afterwards.
- R7: A coefficient write is ignored in any cycle where `in_valid` is high or a beat sits in any of the first three stages. The old weights remain in use.
- R8: While reset is held low, `out_valid` is 0, `out_data` is all zero and all coefficients are zero.
- R9: While `out_valid` is low, `out_data` keeps the last value it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on in_data |
| in_data | input | 21*DW | Neighbourhood samples, signed, packed per R2 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_x | input | CW | Weight for the horizontal neighbour pair, signed |
| coef_y | input | CW | Weight for the vertical neighbour pair, signed |
| coef_c | input | CW | Weight for the centre sample, signed |
| out_valid | output | 1 | Tile result present on out_data |
| out_data | output | 9*(DW+CW+3) | Nine updated points, signed, packed per R2 |

## Verification
Two functions can land on the same clock edge. One is a coefficient write and the other is a beat entering or moving through the first three stages. The bench provokes this directly by raising `coef_we` together with `in_valid`, and again in the cycles just after a beat. Random traffic then mixes write strobes into streams with gaps. A bench model decides from its own record of beats in flight whether each write should land. It computes every expected tile with the weights that model holds when the beat is presented. Any write that slips through while busy therefore shows up as wrong output values on a later tile.

// File: rtl/heat_tile_pipe.sv
module heat_tile_pipe #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [21*DW-1:0]          in_data,
  input  logic                      coef_we,
  input  logic [CW-1:0]             coef_x,
  input  logic [CW-1:0]             coef_y,
  input  logic [CW-1:0]             coef_c,
  output logic                      out_valid,
  output logic [9*(DW+CW+3)-1:0]    out_data
);
  localparam int PW = DW + 1;
  localparam int MW = DW + CW + 1;
  localparam int SW = MW + 1;
  localparam int OW = DW + CW + 3;

  function automatic int widx(input int r, input int c);
    if (r == 0) return c - 1;
    if (r == 4) return 17 + c;
    return 3 + (r - 1) * 5 + c;
  endfunction

  logic [3:0] vld;
  logic signed [CW-1:0] kx, ky, kc;
  logic busy;

  assign busy      = in_valid | vld[0] | vld[1] | vld[2];
  assign out_valid = vld[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      kx  <= '0;
      ky  <= '0;
      kc  <= '0;
    end else begin
      vld <= {vld[2:0], in_valid};
      if (coef_we && !busy) begin
        kx <= coef_x;
        ky <= coef_y;
        kc <= coef_c;
      end
    end
  end

  for (genvar g = 0; g < 9; g++) begin : g_pt
    localparam int R  = g / 3 + 1;
    localparam int C  = g % 3 + 1;
    localparam int IL = widx(R, C - 1);
    localparam int IR = widx(R, C + 1);
    localparam int IU = widx(R - 1, C);
    localparam int ID = widx(R + 1, C);
    localparam int IC = widx(R, C);

    logic signed [DW-1:0] sl, sr, su, sd, sc;
    logic signed [PW-1:0] hs, vs, ct;
    logic signed [MW-1:0] mx, my, mc;
    logic signed [SW-1:0] s1, c3;
    logic signed [OW-1:0] od;

    assign sl = in_data[IL*DW +: DW];
    assign sr = in_data[IR*DW +: DW];
    assign su = in_data[IU*DW +: DW];
    assign sd = in_data[ID*DW +: DW];
    assign sc = in_data[IC*DW +: DW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hs <= '0; vs <= '0; ct <= '0;
        mx <= '0; my <= '0; mc <= '0;
        s1 <= '0; c3 <= '0; od <= '0;
      end else begin
        if (in_valid) begin
          hs <= PW'(sl) + PW'(sr);
          vs <= PW'(su) + PW'(sd);
          ct <= PW'(sc);
        end
        if (vld[0]) begin
          mx <= MW'(kx) * MW'(hs);
          my <= MW'(ky) * MW'(vs);
          mc <= MW'(kc) * MW'(ct);
        end
        if (vld[1]) begin
          s1 <= SW'(mx) + SW'(my);
          c3 <= SW'(mc);
        end
        if (vld[2]) od <= OW'(s1) + OW'(c3);
      end
    end

    assign out_data[g*OW +: OW] = od;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4)); // R3

  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(kx) && $stable(ky) && $stable(kc))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R9

  AST_ZERO_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_data, 4) == '0) |-> out_data == '0); // R1
endmodule

// File: tb/tb_heat_tile_pipe.sv
module tb_heat_tile_pipe;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int OW = DW + CW + 3;
  localparam int IW = 21 * DW;
  localparam int XW = 9 * OW;

  logic clk = 0, rst_n = 0, in_valid = 0, coef_we = 0;
  logic [IW-1:0] in_data = '0;
  logic [CW-1:0] coef_x = '0, coef_y = '0, coef_c = '0;
  logic out_valid;
  logic [XW-1:0] out_data;

  heat_tile_pipe #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_x(coef_x), .coef_y(coef_y), .coef_c(coef_c),
    .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R8";
  longint mkx = 0, mky = 0, mkc = 0;
  logic hv [0:3];
  logic [XW-1:0] he [0:3];
  logic pv = 0;
  logic [XW-1:0] pe = '0;
  logic [XW-1:0] last_out = '0;
  bit done = 0;

  function automatic int pos(input int r, input int c);
    if (r == 0) return c - 1;
    if (r == 4) return 17 + c;
    return 3 + (r - 1) * 5 + c;
  endfunction

  function automatic longint smp(input logic [IW-1:0] d, input int r, input int c);
    logic signed [DW-1:0] v;
    v = d[pos(r, c)*DW +: DW];
    return longint'(v);
  endfunction

  function automatic logic [XW-1:0] model(input logic [IW-1:0] d);
    logic [XW-1:0] res;
    res = '0;
    for (int p = 0; p < 3; p++)
      for (int q = 0; q < 3; q++) begin
        longint a;
        int r, c;
        r = p + 1; c = q + 1;
        a = mkx * (smp(d, r, c-1) + smp(d, r, c+1))
          + mky * (smp(d, r-1, c) + smp(d, r+1, c))
          + mkc * smp(d, r, c);
        res[(3*p+q)*OW +: OW] = a[OW-1:0];
      end
    return res;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [IW-1:0] d, input logic we,
                       input logic [CW-1:0] x, input logic [CW-1:0] y, input logic [CW-1:0] c);
    bit busy;
    @(negedge clk);
    for (int k = 3; k > 0; k--) begin hv[k] = hv[k-1]; he[k] = he[k-1]; end
    hv[0] = pv; he[0] = pe;
    chk(out_valid == hv[3], "out_valid", XW'(out_valid), XW'(hv[3]));
    if (hv[3]) begin
      chk(out_data == he[3], "tile", out_data, he[3]);
      last_out = he[3];
    end else
      chk(out_data == last_out, "hold R9", out_data, last_out);
    busy = v | hv[0] | hv[1] | hv[2];
    if (we && !busy) begin
      mkx = longint'($signed(x)); mky = longint'($signed(y)); mkc = longint'($signed(c));
    end
    pv = v;
    if (v) pe = model(d);
    in_valid = v; in_data = d; coef_we = we;
    coef_x = x; coef_y = y; coef_c = c;
  endtask

  function automatic logic [IW-1:0] rnd();
    logic [IW-1:0] d;
    for (int k = 0; k < 21; k++) d[k*DW +: DW] = DW'($urandom());
    return d;
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(0, '0, 0, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] d;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin hv[k] = 0; he[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R8";
    chk(out_valid == 0, "reset valid", XW'(out_valid), '0);
    chk(out_data == '0, "reset data", out_data, '0);
    rst_n = 1;
    // reset coefficients are zero: a beat gives all-zero output
    tag = "R8";
    cycle(1, rnd(), 0, '0, '0, '0);
    idle(5);

    // R6 idle load, R1 R2 impulse at centre index 10 and at edge index 0
    tag = "R6";
    cycle(0, '0, 1, CW'(3), CW'(5), CW'(7));
    tag = "R1";
    d = '0; d[10*DW +: DW] = DW'(1);
    cycle(1, d, 0, '0, '0, '0);
    tag = "R2";
    d = '0; d[0*DW +: DW] = DW'(-2); d[20*DW +: DW] = DW'(9); d[3*DW +: DW] = DW'(4);
    cycle(1, d, 0, '0, '0, '0);
    tag = "R3";
    idle(6);

    // R5 extremes
    tag = "R5";
    cycle(0, '0, 1, {1'b1, {(CW-1){1'b0}}}, {1'b1, {(CW-1){1'b0}}}, {1'b1, {(CW-1){1'b0}}});
    cycle(1, {21{1'b1, {(DW-1){1'b0}}}}, 0, '0, '0, '0);
    cycle(0, '0, 1, {1'b0, {(CW-1){1'b1}}}, {1'b0, {(CW-1){1'b1}}}, {1'b0, {(CW-1){1'b1}}});
    idle(5);
    cycle(0, '0, 1, {1'b0, {(CW-1){1'b1}}}, {1'b1, {(CW-1){1'b0}}}, {1'b0, {(CW-1){1'b1}}});
    cycle(1, {21{1'b1, {(DW-1){1'b0}}}}, 0, '0, '0, '0);
    idle(5);

    // R4 back to back
    tag = "R4";
    cycle(0, '0, 1, CW'($urandom()), CW'($urandom()), CW'($urandom()));
    for (int k = 0; k < 40; k++) cycle(1, rnd(), 0, '0, '0, '0);
    idle(5);

    // R7 writes collide with in_valid and with beats in flight
    tag = "R7";
    cycle(1, rnd(), 1, CW'(11), CW'(-13), CW'(17));
    cycle(0, '0, 1, CW'(19), CW'(23), CW'(-29));
    cycle(0, '0, 1, CW'(31), CW'(37), CW'(41));
    cycle(0, '0, 1, CW'(43), CW'(47), CW'(53));
    idle(2);
    cycle(1, rnd(), 0, '0, '0, '0);
    idle(5);

    // mixed random traffic
    tag = "R1";
    for (int k = 0; k < 400; k++)
      cycle(($urandom() % 3) != 0, rnd(), ($urandom() % 5) == 0,
            CW'($urandom()), CW'($urandom()), CW'($urandom()));
    idle(6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule